// File: doc/BRIEF.md
# Serial-Loaded Latched Switch Controller

This block produces eight independent on/off enable lines for a bank of analog switches. Settings arrive bit by bit on a serial input and are shifted into an eight-stage register on rising edges of the system clock whenever a shift qualifier is high. A bank of holding stages sits between the register and the enable lines. With the latch-enable input low the bank is transparent, so the enables follow the register directly. With latch-enable high the bank freezes the pattern it showed when latch-enable went high, and further shifting cannot disturb the switches.

A clear input forces every enable off at once. It overrides both the register and the frozen pattern, but leaves the stored bits untouched, so releasing clear brings the previous pattern back. The last register stage is brought out as a serial output, which lets several controllers be chained so that one serial stream can load all of them.

Top module: `sw_ctrl_top`

## Requirements
- R1: After a cycle with rst_n low at a clock edge, the shift register and the holding stages are all zero, so every sw_en bit is 0 and sdo is 0.
- R2: At a rising clk edge with shift_en high, sdi enters stage 0 and every stage k moves to stage k+1; the first of eight shifted bits ends up in stage 7 and drives sw_en[7].
- R3: At a rising clk edge with shift_en low, the register keeps its contents.
- R4: While latch_en and clr are both low, sw_en[k] equals register stage k in the same cycle, where 1 means switch on and 0 means off.
- R5: While latch_en is high and clr is low, sw_en holds the pattern shown when latch_en rose; shifting in that time does not change sw_en.
- R6: When latch_en falls with clr low, sw_en shows the current register contents without waiting for a clock edge.
- R7: While clr is high, sw_en is all zeros regardless of sdi, shift_en and latch_en, and neither the register nor the held pattern is altered.
- R8: sdo always equals register stage 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; register updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sdi | input | 1 | Serial data in, entering stage 0 |
| shift_en | input | 1 | Shift qualifier; shift happens at edges where it is high |
| latch_en | input | 1 | Low: enables follow the register; high: enables held |
| clr | input | 1 | Forces all enables off while high |
| sw_en | output | 8 | Switch enable lines, bit k for switch k, 1 = on |
| sdo | output | 1 | Serial data out, copy of stage 7 |

## Verification
The assertions watch every cycle that each shift moves the register by exactly one place, that an idle qualifier or a high latch-enable freezes the corresponding storage, that clear yields all-off enables and that a transparent bank mirrors the register. What only the bench's scenarios show is the behaviour across mode changes: that a held pattern survives many shifts, that it reappears after clear is released, that a falling latch-enable shows the register immediately, and that a bit reaches switch 7 after exactly eight shifts.

// File: rtl/sw_ctrl_pkg.sv
// Package: shared sizing for the serial switch controller.
// Assumes one enable bit per switch and one register stage per switch.
package sw_ctrl_pkg;
    localparam int unsigned SW_COUNT = 8;
    typedef logic [SW_COUNT-1:0] sw_vec_t;
endpackage

// File: rtl/sw_shifter.sv
// Module: serial-in shift register of N_STAGES stages.
// Stage 0 takes serial data, stages move upward on each qualified edge.
// Exposes both the stored value and the value that the next edge will store,
// so that a downstream holding bank can follow without a cycle of lag.
// Assumes a synchronous active-low reset.
module sw_shifter #(
    parameter int unsigned N_STAGES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sdi,
    input  logic                shift_en,
    output logic [N_STAGES-1:0] stage_q,
    output logic [N_STAGES-1:0] stage_nxt
);
    localparam int unsigned TOP = N_STAGES - 1;

    // Next-state value: shift by one place when qualified, otherwise keep.
    always_comb begin
        if (shift_en)
            stage_nxt = {stage_q[TOP-1:0], sdi};
        else
            stage_nxt = stage_q;
    end

    // State register with synchronous reset to all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else
            stage_q <= stage_nxt;
    end

    assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> stage_q == {$past(stage_q[TOP-1:0]), $past(sdi)});

    assert_shift_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(stage_q));
endmodule

// File: rtl/sw_hold_bank.sv
// Module: holding stage bank between register and switch enables.
// While hold is low the bank is transparent and shows the register; the
// internal copy tracks the register's next value so that a rise of hold
// between edges shows the same pattern that was visible just before.
// Assumes a synchronous active-low reset.
module sw_hold_bank #(
    parameter int unsigned N_STAGES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold,
    input  logic [N_STAGES-1:0] stage_q,
    input  logic [N_STAGES-1:0] stage_nxt,
    output logic [N_STAGES-1:0] bank_out
);
    logic [N_STAGES-1:0] frozen_q;

    // Copy register: follows the register while transparent, else keeps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frozen_q <= '0;
        else if (!hold)
            frozen_q <= stage_nxt;
    end

    // Output select: per-stage choice between live and frozen data.
    for (genvar k = 0; k < N_STAGES; k++) begin : g_sel
        assign bank_out[k] = hold ? frozen_q[k] : stage_q[k];
    end

    assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(frozen_q));
endmodule

// File: rtl/sw_ctrl_top.sv
// Module: top of the serial-loaded latched switch controller.
// Chains shift register, holding bank and an overriding clear gate.
// Clear is applied combinationally at the outputs and touches no storage.
// Assumes a free-running clk and a synchronous active-low reset.
module sw_ctrl_top
    import sw_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sdi,
    input  logic                shift_en,
    input  logic                latch_en,
    input  logic                clr,
    output logic [SW_COUNT-1:0] sw_en,
    output logic                sdo
);
    sw_vec_t stage_q;
    sw_vec_t stage_nxt;
    sw_vec_t bank_out;

    sw_shifter #(.N_STAGES(SW_COUNT)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sdi       (sdi),
        .shift_en  (shift_en),
        .stage_q   (stage_q),
        .stage_nxt (stage_nxt)
    );

    sw_hold_bank #(.N_STAGES(SW_COUNT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (latch_en),
        .stage_q   (stage_q),
        .stage_nxt (stage_nxt),
        .bank_out  (bank_out)
    );

    // Clear gate: overrides every enable while clr is high.
    always_comb begin
        sw_en = clr ? '0 : bank_out;
    end

    // Chain output: last register stage.
    assign sdo = stage_q[SW_COUNT-1];

    assert_clear_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> sw_en == '0);

    assert_transparent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_en && !clr) |-> sw_en == stage_q);

    assert_chain_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sdo == $past(stage_q[SW_COUNT-2]));
endmodule

// File: tb/tb_sw_ctrl_top.sv
module tb_sw_ctrl_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sdi = 1'b0;
    logic       shift_en = 1'b0;
    logic       latch_en = 1'b0;
    logic       clr = 1'b0;
    logic [7:0] sw_en;
    logic       sdo;

    int unsigned n_run = 0;
    int unsigned n_fail = 0;
    bit          done = 1'b0;

    logic [7:0] m_sr = 8'h00;
    logic [7:0] m_hold = 8'h00;

    sw_ctrl_top dut (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .shift_en(shift_en),
        .latch_en(latch_en), .clr(clr), .sw_en(sw_en), .sdo(sdo)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] exp_sw();
        if (clr) return 8'h00;
        if (latch_en) return m_hold;
        return m_sr;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string mode_req();
        if (clr) return "R7";
        if (latch_en) return "R5";
        return "R4";
    endfunction

    task automatic check_all();
        chk(mode_req(), sw_en, exp_sw());
        chk("R8", {7'd0, sdo}, {7'd0, m_sr[7]});
    endtask

    // One cycle: drive after the falling edge, check combinational, clock, check.
    task automatic step(input logic d, input logic sh, input logic le, input logic cl);
        @(negedge clk);
        sdi = d; shift_en = sh; latch_en = le; clr = cl;
        #1;
        if (rst_n) check_all();
        @(posedge clk);
        if (!rst_n) begin
            m_sr = 8'h00; m_hold = 8'h00;
        end else begin
            if (sh) m_sr = {m_sr[6:0], d};
            if (!le) m_hold = m_sr;
        end
        #2;
        if (rst_n) check_all();
    endtask

    initial begin
        logic [7:0] pat;
        logic [7:0] kept;
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        repeat (3) step(1'b1, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        #1;
        chk("R1", sw_en, 8'h00);
        chk("R1", {7'd0, sdo}, 8'h00);

        // R2: shift a pattern MSB first; after eight shifts bit 7 is the first bit.
        pat = 8'hA5;
        for (int i = 7; i >= 0; i--) step(pat[i], 1'b1, 1'b0, 1'b0);
        chk("R2", sw_en, 8'hA5);
        chk("R2", {7'd0, sdo}, 8'h01);

        // R3: idle qualifier keeps contents.
        repeat (4) step(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R3", sw_en, 8'hA5);

        // R5: raise latch_en, shift a new pattern, switches stay.
        kept = sw_en;
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R5", sw_en, kept);
        chk("R8", {7'd0, sdo}, 8'h00);

        // R6: falling latch_en shows register immediately.
        @(negedge clk);
        latch_en = 1'b0;
        #1;
        chk("R6", sw_en, 8'h00);

        // R7: clear forces off and preserves storage.
        for (int i = 0; i < 8; i++) step(pat[i], 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        kept = sw_en;
        step(1'b1, 1'b0, 1'b1, 1'b1);
        chk("R7", sw_en, 8'h00);
        step(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R7", sw_en, 8'h00);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R7", sw_en, kept);

        // Random mix with model comparison on every cycle.
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom();
            step(r[0], r[1] | r[2], (r[5:3] == 3'd0) ? ~latch_en : latch_en, r[9:6] == 4'd0);
        end

        // R1 again: reset mid-run clears everything.
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b0;
        step(1'b1, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        #1;
        chk("R1", sw_en, 8'h00);
        chk("R1", {7'd0, sdo}, 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule